// File: doc/BRIEF.md
# Activation Hot-Row Tracker

This block watches the row-activate commands that a memory controller sends to a DRAM and finds the rows that are activated often enough to disturb their neighbours. It does not keep one counter per row. A small fixed table holds candidate rows with their counts, and a new row that misses a full table evicts the entry with the lowest count. The new row inherits that count plus one, so a row that really crosses the limit is never under-counted.

A row is declared hot when its count reaches a threshold that can be changed at run time. The block then reports the row and its count for one cycle. It queues refresh requests for the rows on either side of it and hands them out through a valid/ready handshake. A refresh-window tick clears the whole table. An optional double-sided mode adds the count of the aggressor on the far side of a shared victim. This lets a lower threshold protect against two-sided hammering.

Top module: `hot_row_tracker`

## Requirements
- R1: After reset, `hot_valid` and `vic_valid` are low and the table is empty.
- R2: When an activation brings a row's count to a value at or above `threshold`, `hot_valid` is high on the cycle after that activation, with `hot_row` equal to the row and `hot_count` equal to the count. `threshold` is sampled on the activation's cycle and may change between activations.
- R3: A row that has already been reported in the current window is not reported again while it stays in the table.
- R4: `win_tick` clears every entry. An activation presented in the same cycle as `win_tick` is not counted.
- R5: Each hot report produces refresh requests for row-1 and then row+1, in that order.
- R6: A hot row at address 0 produces only the request for row 1. A hot row at the all-ones address produces only the request for all-ones minus 1.
- R7: On a miss with the table full, the entry with the lowest count is replaced (lowest index on ties). The new row's count becomes that lowest count plus one.
- R8: With `dbl_mode` high, the value compared with the threshold and reported is the row's own count plus the larger of the counts held for row-2 and row+2. These are the two aggressors that share a victim with the row.
- R9: While `vic_valid` is high and `vic_ready` is low, `vic_row` holds. Up to two detections wait in the queue. A detection that finds the queue full is neither reported nor marked, but its count is still updated, so a later activation of that row reports it.
- R10: `vic_valid` is never high unless a hot report has produced a request that has not yet been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | A row activation is present this cycle |
| act_row | input | ROW_W | Row address of the activation |
| win_tick | input | 1 | Refresh-window boundary; clears the table |
| threshold | input | CNT_W | Count at which a row is declared hot |
| dbl_mode | input | 1 | Double-sided counting enable |
| hot_valid | output | 1 | One-cycle hot-row report |
| hot_row | output | ROW_W | Address of the reported row |
| hot_count | output | CNT_W | Count at the time of the report |
| vic_valid | output | 1 | A victim refresh request is offered |
| vic_ready | input | 1 | The consumer takes the offered request |
| vic_row | output | ROW_W | Victim row to refresh |

## Verification
Table lookup, threshold compare and queue push all take place in the activation's cycle. The hot report is registered, so it appears exactly one cycle after the activating edge. The bench drives each activation for a single cycle and samples `hot_valid` at the next falling edge, inside that one-cycle report. A detection also appears as `vic_valid` on that same next cycle. Victim requests are drained one at a time: `vic_ready` is raised at a falling edge, the offered row is read at a falling edge, and the consumed handshake takes effect at the rising edge between them. After the expected number of victims, the bench confirms that `vic_valid` has dropped.

// File: rtl/hrt_pkg.sv
package hrt_pkg;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} vphase_t;

  // number of victim rows that exist around an aggressor
  function automatic int unsigned victim_count(input bit lo_ok, input bit hi_ok);
    return (lo_ok ? 1 : 0) + (hi_ok ? 1 : 0);
  endfunction

endpackage

// File: rtl/hrt_table.sv
module hrt_table #(
  parameter int ENTRIES = 16,
  parameter int ROW_W   = 16,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             upd,
  input  logic [ROW_W-1:0] row,
  input  logic             dbl,
  input  logic             mark_rep,
  output logic [CNT_W-1:0] new_cnt,
  output logic [CNT_W-1:0] eff_cnt,
  output logic             rep_hit
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             v_q  [ENTRIES];
  logic             rp_q [ENTRIES];
  logic [ROW_W-1:0] r_q  [ENTRIES];
  logic [CNT_W-1:0] c_q  [ENTRIES];

  function automatic logic [CNT_W-1:0] cnt_inc(input logic [CNT_W-1:0] a);
    return (a == CNT_MAX) ? CNT_MAX : a + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_sum(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CNT_W] ? CNT_MAX : s[CNT_W-1:0];
  endfunction

  logic             hit, free_any;
  logic [IDX_W-1:0] hit_idx, free_idx, min_idx, upd_idx;
  logic [CNT_W-1:0] base_cnt, lo2_cnt, hi2_cnt, nb_cnt;
  logic [ROW_W:0]   lo2_row, hi2_row;

  assign lo2_row = {1'b0, row} - (ROW_W+1)'(2);
  assign hi2_row = {1'b0, row} + (ROW_W+1)'(2);

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    free_any = 1'b0;
    free_idx = '0;
    min_idx = '0;
    lo2_cnt = '0;
    hi2_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (v_q[i] && r_q[i] == row && !hit) begin
        hit = 1'b1;
        hit_idx = IDX_W'(i);
      end
      if (!v_q[i] && !free_any) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
      if (c_q[i] < c_q[min_idx]) min_idx = IDX_W'(i);
      if (v_q[i] && !lo2_row[ROW_W] && r_q[i] == lo2_row[ROW_W-1:0]) lo2_cnt = c_q[i];
      if (v_q[i] && !hi2_row[ROW_W] && r_q[i] == hi2_row[ROW_W-1:0]) hi2_cnt = c_q[i];
    end
  end

  always_comb begin
    if (hit) begin
      upd_idx  = hit_idx;
      base_cnt = c_q[hit_idx];
    end else if (free_any) begin
      upd_idx  = free_idx;
      base_cnt = '0;
    end else begin
      upd_idx  = min_idx;
      base_cnt = c_q[min_idx];
    end
  end

  assign new_cnt = cnt_inc(base_cnt);
  assign nb_cnt  = (lo2_cnt > hi2_cnt) ? lo2_cnt : hi2_cnt;
  assign eff_cnt = dbl ? cnt_sum(new_cnt, nb_cnt) : new_cnt;
  assign rep_hit = hit && rp_q[hit_idx];

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      for (int i = 0; i < ENTRIES; i++) begin
        v_q[i]  <= 1'b0;
        rp_q[i] <= 1'b0;
        r_q[i]  <= '0;
        c_q[i]  <= '0;
      end
    end else if (upd) begin
      v_q[upd_idx]  <= 1'b1;
      r_q[upd_idx]  <= row;
      c_q[upd_idx]  <= new_cnt;
      rp_q[upd_idx] <= rep_hit || mark_rep;
    end
  end

endmodule

// File: rtl/hrt_vq.sv
module hrt_vq #(
  parameter int ROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ROW_W-1:0] push_row,
  output logic             can_push,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [ROW_W-1:0] vic_row
);
  import hrt_pkg::*;

  logic [ROW_W-1:0] slot0_q, slot1_q;
  logic [1:0]       cnt_q;
  vphase_t          ph_q;

  logic lo_ok, hi_ok, cur_lo, last, fire, pop;

  function automatic logic [ROW_W-1:0] victim_of(input logic [ROW_W-1:0] aggr,
                                                 input logic lower);
    return lower ? aggr - 1'b1 : aggr + 1'b1;
  endfunction

  assign lo_ok     = slot0_q != '0;
  assign hi_ok     = slot0_q != '1;
  assign cur_lo    = (ph_q == PH_LOW) && lo_ok;
  assign last      = !cur_lo || !hi_ok;
  assign vic_valid = cnt_q != 2'd0;
  assign vic_row   = victim_of(slot0_q, cur_lo);
  assign fire      = vic_valid && vic_ready;
  assign pop       = fire && last;
  assign can_push  = cnt_q != 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot0_q <= '0;
      slot1_q <= '0;
      cnt_q   <= 2'd0;
      ph_q    <= PH_LOW;
    end else begin
      if (push && !pop) begin
        if (cnt_q == 2'd0) slot0_q <= push_row;
        else               slot1_q <= push_row;
        cnt_q <= cnt_q + 2'd1;
      end else if (pop && !push) begin
        slot0_q <= slot1_q;
        cnt_q   <= cnt_q - 2'd1;
      end else if (pop && push) begin
        if (cnt_q == 2'd1) slot0_q <= push_row;
        else begin
          slot0_q <= slot1_q;
          slot1_q <= push_row;
        end
      end
      if (pop)       ph_q <= PH_LOW;
      else if (fire) ph_q <= PH_HIGH;
    end
  end

endmodule

// File: rtl/hot_row_tracker.sv
module hot_row_tracker #(
  parameter int ENTRIES = 16,
  parameter int ROW_W   = 16,
  parameter int CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_valid,
  input  logic [ROW_W-1:0] act_row,
  input  logic             win_tick,
  input  logic [CNT_W-1:0] threshold,
  input  logic             dbl_mode,
  output logic             hot_valid,
  output logic [ROW_W-1:0] hot_row,
  output logic [CNT_W-1:0] hot_count,
  output logic             vic_valid,
  input  logic             vic_ready,
  output logic [ROW_W-1:0] vic_row
);

  logic             upd, det_hot, det_push, q_room, rep_hit;
  logic [CNT_W-1:0] new_cnt, eff_cnt;

  // activations on a window tick are dropped
  assign upd      = act_valid && !win_tick;
  assign det_hot  = upd && (eff_cnt >= threshold) && !rep_hit;
  assign det_push = det_hot && q_room;

  hrt_table #(.ENTRIES(ENTRIES), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (win_tick),
    .upd      (upd),
    .row      (act_row),
    .dbl      (dbl_mode),
    .mark_rep (det_push),
    .new_cnt  (new_cnt),
    .eff_cnt  (eff_cnt),
    .rep_hit  (rep_hit)
  );

  hrt_vq #(.ROW_W(ROW_W)) u_vq (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (det_push),
    .push_row  (act_row),
    .can_push  (q_room),
    .vic_valid (vic_valid),
    .vic_ready (vic_ready),
    .vic_row   (vic_row)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot_valid <= 1'b0;
      hot_row   <= '0;
      hot_count <= '0;
    end else begin
      hot_valid <= det_push;
      if (det_push) begin
        hot_row   <= act_row;
        hot_count <= eff_cnt;
      end
    end
  end

endmodule

// File: rtl/hrt_checker.sv
module hrt_checker #(
  parameter int ROW_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             win_tick,
  input logic [CNT_W-1:0] threshold,
  input logic             hot_valid,
  input logic [ROW_W-1:0] hot_row,
  input logic [CNT_W-1:0] hot_count,
  input logic             vic_valid,
  input logic             vic_ready,
  input logic [ROW_W-1:0] vic_row
);
  import hrt_pkg::*;

  logic [2:0] pend_q;
  logic [2:0] add_n;

  assign add_n = hot_valid ? 3'(victim_count(hot_row != '0, hot_row != '1)) : 3'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 3'd0;
    else        pend_q <= pend_q + add_n - ((vic_valid && vic_ready) ? 3'd1 : 3'd0);
  end

  // R2: a report never carries a count below the threshold in force
  a_r2_hot_meets_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    hot_valid |-> hot_count >= $past(threshold));

  // R4: an activation on the tick cycle cannot produce a report
  a_r4_tick_no_report: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_tick) |-> !hot_valid);

  // R9: a stalled request holds its row
  a_r9_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (vic_valid && !vic_ready) |=> (vic_valid && $stable(vic_row)));

  // R10: requests only follow hot reports
  a_r10_no_spurious_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    vic_valid |-> (pend_q != 3'd0 || hot_valid));

endmodule

bind hot_row_tracker hrt_checker #(.ROW_W(ROW_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .win_tick  (win_tick),
  .threshold (threshold),
  .hot_valid (hot_valid),
  .hot_row   (hot_row),
  .hot_count (hot_count),
  .vic_valid (vic_valid),
  .vic_ready (vic_ready),
  .vic_row   (vic_row)
);

// File: tb/hot_row_tracker_tb.sv
module hot_row_tracker_tb;
  localparam int ROW_W = 16;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             act_valid = 1'b0;
  logic [ROW_W-1:0] act_row = '0;
  logic             win_tick = 1'b0;
  logic [CNT_W-1:0] threshold = 16'd4;
  logic             dbl_mode = 1'b0;
  logic             hot_valid;
  logic [ROW_W-1:0] hot_row;
  logic [CNT_W-1:0] hot_count;
  logic             vic_valid;
  logic             vic_ready = 1'b0;
  logic [ROW_W-1:0] vic_row;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hot_row_tracker #(.ENTRIES(16), .ROW_W(ROW_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_row(act_row),
    .win_tick(win_tick), .threshold(threshold), .dbl_mode(dbl_mode),
    .hot_valid(hot_valid), .hot_row(hot_row), .hot_count(hot_count),
    .vic_valid(vic_valid), .vic_ready(vic_ready), .vic_row(vic_row)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // one activation; report is sampled on the following falling edge
  task automatic act(input logic [ROW_W-1:0] row, input bit exp_hot,
                     input longint exp_cnt, input string tag);
    act_valid = 1'b1;
    act_row   = row;
    @(negedge clk);
    act_valid = 1'b0;
    chk(hot_valid == exp_hot, tag, hot_valid, exp_hot);
    if (exp_hot && hot_valid) begin
      chk(hot_row == row, tag, hot_row, row);
      chk(hot_count == exp_cnt, tag, hot_count, exp_cnt);
    end
  endtask

  task automatic act_quiet(input logic [ROW_W-1:0] row);
    act_valid = 1'b1;
    act_row   = row;
    @(negedge clk);
    act_valid = 1'b0;
  endtask

  task automatic tick();
    win_tick = 1'b1;
    @(negedge clk);
    win_tick = 1'b0;
  endtask

  task automatic take(input logic [ROW_W-1:0] exp_row, input string tag);
    int waited = 0;
    vic_ready = 1'b1;
    while (!vic_valid && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk(vic_valid && vic_row == exp_row, tag, vic_row, exp_row);
    @(negedge clk);
    vic_ready = 1'b0;
  endtask

  task automatic idle(input string tag);
    chk(!vic_valid, tag, vic_valid, 0);
  endtask

  task automatic t_reset();
    chk(!hot_valid, "R1 hot_valid after reset", hot_valid, 0);
    chk(!vic_valid, "R1 vic_valid after reset", vic_valid, 0);
  endtask

  task automatic t_single();
    threshold = 16'd4;
    act(16'd100, 0, 0, "R2 below threshold 1");
    act(16'd100, 0, 0, "R2 below threshold 2");
    act(16'd100, 0, 0, "R2 below threshold 3");
    idle("R10 no request before hot");
    act(16'd100, 1, 4, "R2 report at threshold");
    take(16'd99, "R5 lower victim first");
    take(16'd101, "R5 upper victim second");
    idle("R5 exactly two victims");
    act(16'd100, 0, 0, "R3 no duplicate report");
    idle("R3 no duplicate victims");
  endtask

  task automatic t_window();
    win_tick  = 1'b1;
    act(16'd100, 0, 0, "R4 activation on tick");
    win_tick  = 1'b0;
    act(16'd100, 0, 0, "R4 count cleared 1");
    act(16'd100, 0, 0, "R4 count cleared 2");
    act(16'd100, 0, 0, "R4 tick activation not counted");
    act(16'd100, 1, 4, "R4 report again in new window");
    take(16'd99, "R4 victim low");
    take(16'd101, "R4 victim high");
  endtask

  task automatic t_edges();
    tick();
    threshold = 16'd1;
    act(16'd0, 1, 1, "R6 row zero hot");
    take(16'd1, "R6 row zero only upper");
    idle("R6 row zero single victim");
    act(16'hFFFF, 1, 1, "R6 top row hot");
    take(16'hFFFE, "R6 top row only lower");
    idle("R6 top row single victim");
  endtask

  task automatic t_replace();
    tick();
    threshold = 16'd20;
    for (int i = 0; i < 16; i++) act_quiet(16'(1000 + i));
    for (int k = 1; k <= 18; k++) act(16'd2000, 0, 0, "R7 not yet hot");
    idle("R10 quiet while below threshold");
    act(16'd2000, 1, 20, "R7 inherited min count plus one");
    take(16'd1999, "R7 victim low");
    take(16'd2001, "R7 victim high");
  endtask

  task automatic t_double();
    tick();
    dbl_mode  = 1'b1;
    threshold = 16'd10;
    for (int i = 0; i < 5; i++) act(16'd500, 0, 0, "R8 first aggressor");
    for (int i = 0; i < 4; i++) act(16'd502, 0, 0, "R8 sum below threshold");
    act(16'd502, 1, 10, "R8 summed count reaches threshold");
    take(16'd501, "R8 victim low");
    take(16'd503, "R8 victim high");
    dbl_mode = 1'b0;
  endtask

  task automatic t_backpressure();
    tick();
    threshold = 16'd2;
    act(16'd10, 0, 0, "R9 row10 first");
    act(16'd10, 1, 2, "R9 row10 queued");
    act(16'd20, 0, 0, "R9 row20 first");
    act(16'd20, 1, 2, "R9 row20 queued");
    act(16'd30, 0, 0, "R9 row30 first");
    act(16'd30, 0, 0, "R9 queue full no report");
    act(16'd30, 0, 0, "R9 still full");
    chk(vic_row == 16'd9, "R9 held row while stalled", vic_row, 9);
    take(16'd9, "R9 drain 1");
    take(16'd11, "R9 drain 2");
    take(16'd19, "R9 drain 3");
    take(16'd21, "R9 drain 4");
    idle("R9 queue empty");
    act(16'd30, 1, 4, "R9 counts updated while full");
    take(16'd29, "R9 deferred low");
    take(16'd31, "R9 deferred high");
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_window();
    t_edges();
    t_replace();
    t_double();
    t_backpressure();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule